// File: doc/BRIEF.md
# Handshake System Bus Master

This block lets internal logic run read and write cycles on a 32-bit external system bus where the slave paces each transfer. The requester gives a word address, a byte mask, a direction and a burst length. The block then runs the bus operation. A one-clock active-low start strobe opens the operation. An active-low last marker covers the final transfer. Each transfer waits as many clocks as needed for the slave's active-low acknowledge, or ends on its active-low bus-error.

Every completed word is reported on the internal side in the cycle its final acknowledge is sampled. Read data is returned in that same cycle. The write data for a word is taken from the requester during every bus cycle of that word. The requester moves on to the next word once a word completes.

A narrow-bus input selects a 16-bit data path. In that mode each word travels as two half-word transfers on data bits 15:0. The lower half-word goes first.

Top module: `sysbus_master`

## Requirements
- R1: The active-low start strobe `bus_start_n` is low for exactly one clock per operation. That clock is the first bus cycle, the cycle right after the request is accepted (`req_valid` high while `req_ready` is high at a rising edge).
- R2: `bus_rd_wr` is 1 during a read and 0 during a write. `bus_wdata_oe` is high only during the bus cycles of a write.
- R3: A bus transfer completes only in a cycle where `bus_ack_n` is low, after any number of wait cycles. On the cycle that completes a word, `beat_done` is high and, for reads, `beat_rdata` holds the word.
- R4: `bus_addr`, `bus_be_n` and `bus_rd_wr` stay constant from the first cycle of a transfer until the cycle in which the slave acknowledges or reports an error.
- R5: A burst moves `req_len`+1 words. The word address `req_addr[31:2]` advances by one (4 bytes) after each completed word. `xfer_done` is high on the final acknowledge, and `req_ready` is high again in the next cycle.
- R6: `bus_last_n` is low during every cycle of the final bus transfer of an operation and high during all earlier transfers.
- R7: `bus_err_n` low ends the operation at once. `xfer_done` and `xfer_err` are high together, no further transfers start, and an error overrides an acknowledge given in the same cycle.
- R8: In 32-bit mode, `bus_be_n[i]` equals the inverse of `req_be[i]`, where enable 3 covers data bits 31:24, enable 2 covers 23:16, enable 1 covers 15:8 and enable 0 covers 7:0. `bus_wdata` equals the requester's word and `bus_addr[1]` is 0.
- R9: With `narrow_mode`=1, each word takes two transfers. The first has `bus_addr[1]`=0, data bits 15:0 of the word, and `bus_be_n[1:0]` = ~`req_be[1:0]`. The second has `bus_addr[1]`=1, data bits 31:16 of the word on `bus_wdata[15:0]`, and `bus_be_n[1:0]` = ~`req_be[3:2]`. In both, `bus_be_n[3:2]` stays 2'b11 and `bus_wdata[31:16]` is 0. The returned word is {second `bus_rdata[15:0]`, first `bus_rdata[15:0]`}.
- R10: While idle, and during reset, `req_ready` is 1, `bus_start_n` and `bus_last_n` are 1, `bus_be_n` is 4'hF, and `bus_wdata_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| narrow_mode | input | 1 | 1 selects the 16-bit data path; sampled at request acceptance |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 30 | Word address (byte address bits 31:2) |
| req_be | input | 4 | Byte mask applied to every word |
| req_len | input | 3 | Number of words minus one |
| req_wdata | input | 32 | Write data of the current word |
| beat_done | output | 1 | Current word completed this cycle |
| beat_rdata | output | 32 | Read word, valid with beat_done |
| xfer_done | output | 1 | Operation ends this cycle |
| xfer_err | output | 1 | Operation ends with a bus error |
| bus_addr | output | 31 | Bus address bits 31:1 |
| bus_be_n | output | 4 | Active-low byte enables |
| bus_rd_wr | output | 1 | 1 = read, 0 = write |
| bus_start_n | output | 1 | Active-low start strobe |
| bus_last_n | output | 1 | Active-low last-transfer marker |
| bus_wdata | output | 32 | Write data |
| bus_wdata_oe | output | 1 | Write data drive enable |
| bus_rdata | input | 32 | Read data from the slave |
| bus_ack_n | input | 1 | Active-low slave acknowledge |
| bus_err_n | input | 1 | Active-low slave bus error |

## Verification
The assertions check the following on every cycle:
- the start strobe is a single clock and follows each acceptance;
- address, enables and direction hold while the slave stalls;
- completions only coincide with an acknowledge;
- the error flag implies the end of an operation;
- the return to idle, and the quiet idle outputs.

Only the bench scenarios can show:
- the address sequence of bursts;
- the half-word order and lane mapping in narrow mode;
- the placement of the last marker;
- read-word assembly;
- that an error on any transfer really stops the rest.

These are shown by sweeping direction, mode, burst length, wait count and error position.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  localparam int unsigned SBM_DATA_W = 32;
  localparam int unsigned SBM_BE_W   = SBM_DATA_W / 8;
  localparam int unsigned SBM_HALF_W = SBM_DATA_W / 2;

  typedef enum logic {
    SBM_IDLE = 1'b0,
    SBM_BUS  = 1'b1
  } sbm_state_e;
endpackage

// File: rtl/sbm_rst_sync.sv
module sbm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sbm_ctrl.sv
module sbm_ctrl
  import sbm_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 narrow_i,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:2]    req_addr,
  input  logic [SBM_BE_W-1:0]  req_be,
  input  logic [LEN_W-1:0]     req_len,
  input  logic                 ack_n,
  input  logic                 err_n,
  output logic                 req_ready,
  output logic                 busy_o,
  output logic                 first_o,
  output logic                 final_o,
  output logic                 half_o,
  output logic                 narrow_o,
  output logic                 wr_o,
  output logic [SBM_BE_W-1:0]  be_o,
  output logic [ADDR_W-1:2]    waddr_o,
  output logic                 lo_take_o,
  output logic                 word_done_o,
  output logic                 xfer_done_o,
  output logic                 xfer_err_o
);
  sbm_state_e              state_q, state_d;
  logic                    first_q, first_d;
  logic                    half_q, half_d;
  logic                    narrow_q, narrow_d;
  logic                    wr_q, wr_d;
  logic [SBM_BE_W-1:0]     be_q, be_d;
  logic [ADDR_W-1:2]       waddr_q, waddr_d;
  logic [LEN_W-1:0]        left_q, left_d;
  logic                    busy, ack, err, half_last, last_word;
  logic                    ctx_en, step_en;

  assign busy      = (state_q == SBM_BUS);
  assign err       = busy & ~err_n;
  assign ack       = busy & ~ack_n & ~err;
  assign half_last = ~narrow_q | half_q;
  assign last_word = (left_q == '0);

  // Clock enables: context loads on acceptance, sequencing moves on a slave response.
  assign ctx_en  = (state_q == SBM_IDLE) & req_valid;
  assign step_en = ack | err;

  always_comb begin
    state_d  = state_q;
    first_d  = 1'b0;
    half_d   = half_q;
    narrow_d = narrow_q;
    wr_d     = wr_q;
    be_d     = be_q;
    waddr_d  = waddr_q;
    left_d   = left_q;
    unique case (state_q)
      SBM_IDLE: begin
        if (req_valid) begin
          state_d  = SBM_BUS;
          first_d  = 1'b1;
          half_d   = 1'b0;
          narrow_d = narrow_i;
          wr_d     = req_write;
          be_d     = req_be;
          waddr_d  = req_addr;
          left_d   = req_len;
        end
      end
      SBM_BUS: begin
        if (err) begin
          state_d = SBM_IDLE;
          half_d  = 1'b0;
        end else if (ack) begin
          if (!half_last) begin
            half_d = 1'b1;
          end else begin
            half_d = 1'b0;
            if (last_word) begin
              state_d = SBM_IDLE;
            end else begin
              left_d  = left_q - 1'b1;
              waddr_d = waddr_q + 1'b1;
            end
          end
        end
      end
      default: state_d = SBM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SBM_IDLE;
      first_q <= 1'b0;
    end else begin
      state_q <= state_d;
      first_q <= first_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      narrow_q <= 1'b0;
      wr_q     <= 1'b0;
      be_q     <= '0;
    end else if (ctx_en) begin
      narrow_q <= narrow_d;
      wr_q     <= wr_d;
      be_q     <= be_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q  <= 1'b0;
      waddr_q <= '0;
      left_q  <= '0;
    end else if (ctx_en || step_en) begin
      half_q  <= half_d;
      waddr_q <= waddr_d;
      left_q  <= left_d;
    end
  end

  assign req_ready   = ~busy;
  assign busy_o      = busy;
  assign first_o     = first_q;
  assign final_o     = busy & last_word & half_last;
  assign half_o      = half_q;
  assign narrow_o    = narrow_q;
  assign wr_o        = wr_q;
  assign be_o        = be_q;
  assign waddr_o     = waddr_q;
  assign lo_take_o   = ack & narrow_q & ~half_q;
  assign word_done_o = ack & half_last;
  assign xfer_done_o = err | (ack & half_last & last_word);
  assign xfer_err_o  = err;
endmodule

// File: rtl/sbm_lane.sv
module sbm_lane
  import sbm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  busy,
  input  logic                  narrow_q,
  input  logic                  half_q,
  input  logic                  lo_take,
  input  logic [SBM_BE_W-1:0]   be_q,
  input  logic [SBM_DATA_W-1:0] wdata_i,
  input  logic [SBM_DATA_W-1:0] rdata_i,
  output logic [SBM_BE_W-1:0]   bus_be_n,
  output logic [SBM_DATA_W-1:0] bus_wdata,
  output logic [SBM_DATA_W-1:0] beat_rdata
);
  localparam int unsigned HBE = SBM_BE_W / 2;

  logic [SBM_HALF_W-1:0] rd_lo_q;
  logic [HBE-1:0]        half_be;
  logic [SBM_HALF_W-1:0] half_wd;

  assign half_be = half_q ? be_q[SBM_BE_W-1:HBE] : be_q[HBE-1:0];
  assign half_wd = half_q ? wdata_i[SBM_DATA_W-1:SBM_HALF_W] : wdata_i[SBM_HALF_W-1:0];

  always_comb begin
    if (!busy)         bus_be_n = '1;
    else if (narrow_q) bus_be_n = {{HBE{1'b1}}, ~half_be};
    else               bus_be_n = ~be_q;
  end

  assign bus_wdata  = narrow_q ? {{SBM_HALF_W{1'b0}}, half_wd} : wdata_i;
  assign beat_rdata = narrow_q ? {rdata_i[SBM_HALF_W-1:0], rd_lo_q} : rdata_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_lo_q <= '0;
    else if (lo_take) rd_lo_q <= rdata_i[SBM_HALF_W-1:0];
  end
endmodule

// File: rtl/sysbus_master.sv
module sysbus_master
  import sbm_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned LEN_W     = 3,
  parameter bit          NARROW_EN = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  narrow_mode,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:2]     req_addr,
  input  logic [SBM_BE_W-1:0]   req_be,
  input  logic [LEN_W-1:0]      req_len,
  input  logic [SBM_DATA_W-1:0] req_wdata,
  output logic                  beat_done,
  output logic [SBM_DATA_W-1:0] beat_rdata,
  output logic                  xfer_done,
  output logic                  xfer_err,
  output logic [ADDR_W-1:1]     bus_addr,
  output logic [SBM_BE_W-1:0]   bus_be_n,
  output logic                  bus_rd_wr,
  output logic                  bus_start_n,
  output logic                  bus_last_n,
  output logic [SBM_DATA_W-1:0] bus_wdata,
  output logic                  bus_wdata_oe,
  input  logic [SBM_DATA_W-1:0] bus_rdata,
  input  logic                  bus_ack_n,
  input  logic                  bus_err_n
);
  logic                rst_sync_n;
  logic                narrow_eff;
  logic                busy, first, final_beat, half_q, narrow_q, wr_q, lo_take;
  logic [SBM_BE_W-1:0] be_q;
  logic [ADDR_W-1:2]   waddr_q;

  generate
    if (NARROW_EN) begin : g_narrow
      assign narrow_eff = narrow_mode;
    end else begin : g_wide_only
      assign narrow_eff = 1'b0;
    end
  endgenerate

  sbm_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sbm_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .narrow_i    (narrow_eff),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_be      (req_be),
    .req_len     (req_len),
    .ack_n       (bus_ack_n),
    .err_n       (bus_err_n),
    .req_ready   (req_ready),
    .busy_o      (busy),
    .first_o     (first),
    .final_o     (final_beat),
    .half_o      (half_q),
    .narrow_o    (narrow_q),
    .wr_o        (wr_q),
    .be_o        (be_q),
    .waddr_o     (waddr_q),
    .lo_take_o   (lo_take),
    .word_done_o (beat_done),
    .xfer_done_o (xfer_done),
    .xfer_err_o  (xfer_err)
  );

  sbm_lane u_lane (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .busy       (busy),
    .narrow_q   (narrow_q),
    .half_q     (half_q),
    .lo_take    (lo_take),
    .be_q       (be_q),
    .wdata_i    (req_wdata),
    .rdata_i    (bus_rdata),
    .bus_be_n   (bus_be_n),
    .bus_wdata  (bus_wdata),
    .beat_rdata (beat_rdata)
  );

  assign bus_addr     = {waddr_q, narrow_q & half_q};
  assign bus_rd_wr    = ~(busy & wr_q);
  assign bus_start_n  = ~first;
  assign bus_last_n   = ~final_beat;
  assign bus_wdata_oe = busy & wr_q;
endmodule

// File: rtl/sbm_checker.sv
module sbm_checker #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              beat_done,
  input logic              xfer_done,
  input logic              xfer_err,
  input logic [ADDR_W-1:1] bus_addr,
  input logic [3:0]        bus_be_n,
  input logic              bus_rd_wr,
  input logic              bus_start_n,
  input logic              bus_last_n,
  input logic              bus_wdata_oe,
  input logic              bus_ack_n,
  input logic              bus_err_n
);
  p_start_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_start_n |=> bus_start_n);

  p_start_follows_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !bus_start_n);

  p_oe_only_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wdata_oe |-> (!bus_rd_wr && !req_ready));

  p_done_needs_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    beat_done |-> !bus_ack_n);

  p_hold_while_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && bus_ack_n && bus_err_n) |=>
      ($stable(bus_addr) && $stable(bus_be_n) && $stable(bus_rd_wr)));

  p_ready_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> req_ready);

  p_err_ends_op_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err |-> (xfer_done && !bus_err_n && !beat_done));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_start_n && bus_last_n && bus_be_n == 4'hF && !bus_wdata_oe));
endmodule

bind sysbus_master sbm_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .beat_done    (beat_done),
  .xfer_done    (xfer_done),
  .xfer_err     (xfer_err),
  .bus_addr     (bus_addr),
  .bus_be_n     (bus_be_n),
  .bus_rd_wr    (bus_rd_wr),
  .bus_start_n  (bus_start_n),
  .bus_last_n   (bus_last_n),
  .bus_wdata_oe (bus_wdata_oe),
  .bus_ack_n    (bus_ack_n),
  .bus_err_n    (bus_err_n)
);

// File: tb/sysbus_master_tb.sv
`timescale 1ns/1ps
module sysbus_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        narrow_mode = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [31:2] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [2:0]  req_len = '0;
  logic [31:0] req_wdata = '0;
  logic        beat_done;
  logic [31:0] beat_rdata;
  logic        xfer_done, xfer_err;
  logic [31:1] bus_addr;
  logic [3:0]  bus_be_n;
  logic        bus_rd_wr, bus_start_n, bus_last_n, bus_wdata_oe;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic        bus_ack_n = 1'b1;
  logic        bus_err_n = 1'b1;

  int vectors = 0;
  int fails   = 0;
  bit ended   = 1'b0;

  always #10 clk = ~clk;

  sysbus_master u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] wd(input logic [31:0] a, input int k);
    return (a ^ 32'hC3A5_5A3C) + k * 32'h0101_0101;
  endfunction

  function automatic logic [31:0] slv(input logic [30:0] a31);
    return {a31, 1'b0} ^ 32'h3C5A_A5C3;
  endfunction

  // nb = bus transfers; err_beat < 0 means no error injected.
  task automatic run_op(input bit wr, input logic [31:0] addr, input logic [3:0] be,
                        input int len, input bit nar, input int wt,
                        input int err_beat, input bit err_with_ack);
    int   per = nar ? 2 : 1;
    int   nb  = (len + 1) * per;
    bit   stop = 1'b0;
    logic [15:0] lo_exp = '0;
    @(negedge clk);
    narrow_mode = nar; req_valid = 1'b1; req_write = wr; req_addr = addr[31:2];
    req_be = be; req_len = 3'(len); req_wdata = wd(addr, 0);
    #1 chk(req_ready == 1'b1, "R10 ready when idle", {31'b0, req_ready}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    for (int b = 0; b < nb && !stop; b++) begin
      int          k = b / per;
      int          h = nar ? (b % 2) : 0;
      logic [29:0] w = addr[31:2] + 30'(k);
      logic [30:0] ea = {w, h[0]};
      logic [3:0]  ebe = nar ? {2'b11, (h != 0) ? ~be[3:2] : ~be[1:0]} : ~be;
      logic [31:0] ewd = nar ? {16'h0, (h != 0) ? wd(addr, k) >> 16 : wd(addr, k) & 32'hFFFF} : wd(addr, k);
      logic [31:0] erd;
      for (int c = 0; c <= wt && !stop; c++) begin
        req_wdata = wd(addr, k);
        bus_rdata = nar ? {16'hDEAD, slv(ea)[15:0]} : slv(ea);
        if (c == wt && b == err_beat) begin
          bus_err_n = 1'b0; bus_ack_n = err_with_ack ? 1'b0 : 1'b1;
        end else if (c == wt) begin
          bus_ack_n = 1'b0; bus_err_n = 1'b1;
        end else begin
          bus_ack_n = 1'b1; bus_err_n = 1'b1;
        end
        #1;
        chk(bus_start_n == !(b == 0 && c == 0), "R1 start strobe", {31'b0, bus_start_n}, {31'b0, !(b == 0 && c == 0)});
        chk(bus_addr == ea, nar ? "R9 half-word address" : "R5 burst address", {1'b0, bus_addr}, {1'b0, ea});
        chk(bus_be_n == ebe, nar ? "R9 narrow enables" : "R8 byte enables", {28'b0, bus_be_n}, {28'b0, ebe});
        chk(bus_last_n == !(b == nb - 1), "R6 last marker", {31'b0, bus_last_n}, {31'b0, !(b == nb - 1)});
        chk(bus_rd_wr == !wr && bus_wdata_oe == wr, "R2 direction", {30'b0, bus_rd_wr, bus_wdata_oe}, {30'b0, !wr, wr});
        if (wr) chk(bus_wdata == ewd, nar ? "R9 narrow write data" : "R8 write data", bus_wdata, ewd);
        if (c == wt && b == err_beat) begin
          chk(xfer_done && xfer_err && !beat_done, "R7 error ends op", {29'b0, xfer_done, xfer_err, beat_done}, 32'd6);
          stop = 1'b1;
        end else if (c == wt) begin
          if (nar && h == 0) begin
            lo_exp = slv(ea)[15:0];
            chk(!beat_done && !xfer_done, "R9 no word done after lower half", {30'b0, beat_done, xfer_done}, 32'd0);
          end else begin
            erd = nar ? {slv(ea)[15:0], lo_exp} : slv(ea);
            chk(beat_done, "R3 word done on ack", {31'b0, beat_done}, 32'd1);
            if (!wr) chk(beat_rdata == erd, nar ? "R9 assembled read" : "R3 read data", beat_rdata, erd);
            chk(xfer_done == (k == len) && !xfer_err, "R5 done on final ack", {30'b0, xfer_done, xfer_err}, {30'b0, k == len, 1'b0});
          end
        end else begin
          chk(!beat_done && !xfer_done, "R3 no completion while waiting", {30'b0, beat_done, xfer_done}, 32'd0);
        end
        @(negedge clk);
      end
    end
    bus_ack_n = 1'b1; bus_err_n = 1'b1;
    #1;
    chk(req_ready && bus_start_n && bus_be_n == 4'hF, err_beat >= 0 ? "R7 no transfer after error" : "R5 ready after done",
        {27'b0, req_ready, bus_be_n}, {27'b0, 1'b1, 4'hF});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!ended) begin
      fails++; vectors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    #1;
    chk(req_ready && bus_start_n && bus_last_n && bus_be_n == 4'hF && !bus_wdata_oe,
        "R10 reset state", {26'b0, req_ready, bus_start_n, bus_last_n, bus_be_n == 4'hF, bus_wdata_oe, 1'b0},
        {26'b0, 4'b1111, 2'b00});
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int nar = 0; nar < 2; nar++)
      for (int wr = 0; wr < 2; wr++)
        for (int len = 0; len < 4; len++)
          for (int wt = 0; wt < 3; wt++)
            run_op(wr[0], 32'h0001_2340 + 32'(len * 64 + wt * 4), 4'(len * 5 + wt * 3 + nar * 7 + 1),
                   len, nar[0], wt, -1, 1'b0);
    // Longest burst, full mask
    run_op(1'b1, 32'h7FFF_FFE0, 4'hF, 7, 1'b0, 1, -1, 1'b0);
    run_op(1'b0, 32'h0000_0FF0, 4'hF, 7, 1'b1, 0, -1, 1'b0);
    // Error on every transfer position; even positions also carry an ack
    for (int nar = 0; nar < 2; nar++)
      for (int e = 0; e < (nar != 0 ? 6 : 3); e++)
        run_op(e[0], 32'h00AB_C000 + 32'(e * 16), 4'hA, 2, nar[0], e % 2, e, !e[0]);
    ended = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule